// File: doc/BRIEF.md
# Stoppable Shared Counter

This block keeps one free-running count shared by every processor of an interrupt controller. Each pulse on the clock-enable input advances the count by one while the counter runs. Software can halt the counter, preset it while it is halted, and release it again, all through a small register window. A configuration word reports the halt state together with fixed fields that describe the controller: how many interrupt sources it has and how many processors it serves.

The count can be read through two windows. The privileged window allows all accesses. The user window is read-only. The upper word of the count is not implemented, so both of its addresses read as zero. The live count also goes out as a plain bus to per-processor compare logic. For each processor the block raises a one-cycle match pulse when the count first equals that processor's compare value.

Register accesses are single-cycle requests. A read answers one cycle later with a response strobe. Word addresses: 0 configuration, 1 counter low, 2 counter high, 8 user counter low, 9 user counter high. Any other address reads zero and ignores writes.

Top module: `shctr_top`

## Requirements
- R1: After reset the count is zero, the counter is running, and the halt bit (configuration bit 31) reads 0.
- R2: While running, each cycle with `tick_i` high adds one to the count, and the count wraps from 0xFFFFFFFF to 0. Cycles without a tick leave the count unchanged.
- R3: Writing 1 to configuration bit 31 while running halts the counter. While halted the count holds even when `tick_i` is high.
- R4: Writing 0 to configuration bit 31 while halted restarts the counter. Writing the value bit 31 already has leaves the halt state and the count unchanged.
- R5: A write to address 1 loads the count only while the counter is halted. While the counter runs, such a write is ignored.
- R6: Reads of address 2 and address 9 always return zero.
- R7: A read of address 8 returns the count. Writes to address 8 or 9 change nothing.
- R8: A configuration read returns bit 31 = halt, bits 23:16 = NUM_SRC/8 - 1, bits 11:8 = 0 (counter-width field), bits 7:0 = NUM_PROC. All other bits read 0.
- R9: `match_o[i]` pulses for exactly one cycle, in the cycle after the count first becomes equal to compare value i (slice i of `cmp_flat_i`).
- R10: `rsp_valid_o` rises in the cycle after a read request. `rsp_rdata_o` then holds the value the register had in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count-enable pulse |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | CNT_W | Write data |
| rsp_valid_o | output | 1 | Read response strobe |
| rsp_rdata_o | output | CNT_W | Read response data |
| cmp_flat_i | input | NUM_PROC*CNT_W | Compare values, processor i in slice i |
| count_o | output | CNT_W | Live count for compare logic |
| match_o | output | NUM_PROC | One-cycle equality pulses |

## Verification
The wrap from all ones to zero cannot be reached by ticking from reset within any practical run. The stimulus gets there by halting the counter, presetting it two below the maximum, restarting it and ticking across the boundary, which also exercises the compare channel set to all ones. Requests that arrive in a running state cover the other half of R5: the same preset is written while the counter runs and must be ignored, and halt writes are repeated to show that rewriting the current bit value is inert.

// File: rtl/shctr_pkg.sv
package shctr_pkg;
  localparam int unsigned REG_CFG  = 0;
  localparam int unsigned REG_LO   = 1;
  localparam int unsigned REG_HI   = 2;
  localparam int unsigned REG_ULO  = 8;
  localparam int unsigned REG_UHI  = 9;

  localparam int unsigned CFG_HALT_BIT = 31;
  localparam int unsigned CFG_SRC_LSB  = 16;
  localparam int unsigned CFG_SRC_W    = 8;
  localparam int unsigned CFG_WID_LSB  = 8;
  localparam int unsigned CFG_WID_W    = 4;
  localparam int unsigned CFG_PROC_LSB = 0;
  localparam int unsigned CFG_PROC_W   = 8;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/shctr_core.sv
module shctr_core #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              halt_o
);
  import shctr_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic             halt_q;
  logic             cfg_wr, lo_wr, new_halt;

  assign cfg_wr   = wr_i && (addr_i == ADDR_W'(REG_CFG));
  assign lo_wr    = wr_i && (addr_i == ADDR_W'(REG_LO));
  assign new_halt = wdata_i[CFG_HALT_BIT];

  // Halt state: changes only when the written bit differs.
  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q <= 1'b0;
    end else if (cfg_wr && (new_halt != halt_q)) begin
      halt_q <= new_halt;
    end
  end

  // Count: preset only while halted, advance only while running.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (halt_q) begin
      if (lo_wr) cnt_q <= wdata_i;
    end else if (tick_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign halt_o = halt_q;

  assert_hold_halted_R3: assert property (@(posedge clk) disable iff (rst)
    (halt_q && !lo_wr) |=> (cnt_q == $past(cnt_q)));

  assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (!halt_q && tick_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  assert_no_load_running_R5: assert property (@(posedge clk) disable iff (rst)
    (!halt_q && !tick_i) |=> (cnt_q == $past(cnt_q)));

  assert_same_bit_inert_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && (new_halt == halt_q)) |=> (halt_q == $past(halt_q)));
endmodule

// File: rtl/shctr_regs.sv
module shctr_regs #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned NUM_SRC  = 64,
  parameter int unsigned NUM_PROC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              halt_i,
  output logic              rsp_valid_o,
  output logic [CNT_W-1:0]  rsp_rdata_o
);
  import shctr_pkg::*;

  localparam int unsigned SRC_CODE = (NUM_SRC / 8) - 1;

  logic [CNT_W-1:0] cfg_word;
  logic [CNT_W-1:0] rd_mux;

  always_comb begin
    cfg_word = '0;
    cfg_word[CFG_HALT_BIT] = halt_i;
    cfg_word[CFG_SRC_LSB +: CFG_SRC_W]   = CFG_SRC_W'(SRC_CODE);
    cfg_word[CFG_WID_LSB +: CFG_WID_W]   = '0;
    cfg_word[CFG_PROC_LSB +: CFG_PROC_W] = CFG_PROC_W'(NUM_PROC);
  end

  always_comb begin
    unique case (addr_i)
      ADDR_W'(REG_CFG): rd_mux = cfg_word;
      ADDR_W'(REG_LO):  rd_mux = cnt_i;
      ADDR_W'(REG_ULO): rd_mux = cnt_i;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd_i;
      if (rd_i) rsp_rdata_o <= rd_mux;
    end
  end

  assert_hi_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_i && (addr_i == ADDR_W'(REG_HI) || addr_i == ADDR_W'(REG_UHI)))
    |=> (rsp_rdata_o == '0));

  assert_rsp_latency_R10: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> rsp_valid_o);

  assert_user_lo_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i == ADDR_W'(REG_ULO)) |=> (rsp_rdata_o == $past(cnt_i)));
endmodule

// File: rtl/shctr_match.sv
module shctr_match #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned NUM_PROC = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [CNT_W-1:0]          cnt_i,
  input  logic [NUM_PROC*CNT_W-1:0] cmp_flat_i,
  output logic [NUM_PROC-1:0]       match_o
);
  genvar g;
  generate
    for (g = 0; g < NUM_PROC; g++) begin : g_proc
      logic eq, eq_prev, pulse_q;
      assign eq = (cnt_i == cmp_flat_i[g*CNT_W +: CNT_W]);

      always_ff @(posedge clk) begin
        if (rst) begin
          eq_prev <= 1'b0;
          pulse_q <= 1'b0;
        end else begin
          eq_prev <= eq;
          pulse_q <= eq && !eq_prev;
        end
      end

      assign match_o[g] = pulse_q;

      assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);
    end
  endgenerate
endmodule

// File: rtl/shctr_top.sv
module shctr_top #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned NUM_SRC  = 64,
  parameter int unsigned NUM_PROC = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick_i,
  input  logic                      req_valid_i,
  input  logic                      req_write_i,
  input  logic [ADDR_W-1:0]         req_addr_i,
  input  logic [CNT_W-1:0]          req_wdata_i,
  output logic                      rsp_valid_o,
  output logic [CNT_W-1:0]          rsp_rdata_o,
  input  logic [NUM_PROC*CNT_W-1:0] cmp_flat_i,
  output logic [CNT_W-1:0]          count_o,
  output logic [NUM_PROC-1:0]       match_o
);
  logic [CNT_W-1:0] cnt;
  logic             halt;
  logic             wr, rd;

  assign wr = req_valid_i && req_write_i;
  assign rd = req_valid_i && !req_write_i;

  shctr_core #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_core (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_i(wr), .addr_i(req_addr_i),
    .wdata_i(req_wdata_i), .cnt_o(cnt), .halt_o(halt)
  );

  shctr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC),
               .NUM_PROC(NUM_PROC)) u_regs (
    .clk(clk), .rst(rst), .rd_i(rd), .addr_i(req_addr_i), .cnt_i(cnt),
    .halt_i(halt), .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o)
  );

  shctr_match #(.CNT_W(CNT_W), .NUM_PROC(NUM_PROC)) u_match (
    .clk(clk), .rst(rst), .cnt_i(cnt), .cmp_flat_i(cmp_flat_i),
    .match_o(match_o)
  );

  assign count_o = cnt;

  assert_reset_running_R1: assert property (@(posedge clk)
    $past(rst) && !rst |-> (!halt && cnt == '0));
endmodule

// File: tb/sim_shctr_top.sv
module sim_shctr_top;
  localparam int CNT_W = 32, ADDR_W = 4, NUM_SRC = 64, NUM_PROC = 4;

  logic clk = 0, rst = 1, tick = 0, rv = 0, rw = 0;
  logic [ADDR_W-1:0] ra = '0;
  logic [CNT_W-1:0]  rd = '0;
  logic rsp_valid;
  logic [CNT_W-1:0] rsp_rdata, count;
  logic [NUM_PROC*CNT_W-1:0] cmp;
  logic [NUM_PROC-1:0] match;

  always #2.5 clk = ~clk;

  shctr_top #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC),
              .NUM_PROC(NUM_PROC)) u0 (
    .clk(clk), .rst(rst), .tick_i(tick), .req_valid_i(rv), .req_write_i(rw),
    .req_addr_i(ra), .req_wdata_i(rd), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .cmp_flat_i(cmp), .count_o(count), .match_o(match)
  );

  int checks = 0, errors = 0;
  logic [CNT_W-1:0] exp_q[$];
  string tag_q[$];
  logic [CNT_W-1:0] m_cnt = '0;
  logic m_halt = 0;
  logic [NUM_PROC-1:0] m_eqp = '0, m_pulse = '0;
  bit done = 0;

  function automatic logic [CNT_W-1:0] cfg_exp(input logic h);
    cfg_exp = {h, 7'd0, 8'(NUM_SRC/8 - 1), 4'd0, 4'd0, 8'(NUM_PROC)};
  endfunction

  task automatic chk(input string tag, input logic [CNT_W-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one request per cycle; model updated per requirements.
  task automatic step(input bit tk, input bit v, input bit w,
                      input int a, input logic [CNT_W-1:0] d, input string tag);
    logic nh;
    tick = tk; rv = v; rw = w; ra = ADDR_W'(a); rd = d;
    if (v && !w) begin
      logic [CNT_W-1:0] e;
      case (a)
        0: e = cfg_exp(m_halt);
        1, 8: e = m_cnt;
        default: e = '0;
      endcase
      exp_q.push_back(e); tag_q.push_back(tag);
    end
    for (int i = 0; i < NUM_PROC; i++) begin
      logic eq;
      eq = (m_cnt == cmp[i*CNT_W +: CNT_W]);
      m_pulse[i] = eq && !m_eqp[i];
      m_eqp[i] = eq;
    end
    @(posedge clk);
    nh = (v && w && a == 0) ? d[31] : m_halt;
    if (m_halt) begin
      if (v && w && a == 1) m_cnt = d;
    end else if (tk) m_cnt = m_cnt + 1;
    m_halt = nh;
    @(negedge clk);
    chk("R9 match", CNT_W'(match), CNT_W'(m_pulse));
    chk("R2 count_o", count, m_cnt);
    tick = 0; rv = 0;
  endtask

  // Monitor: pops expected read data as responses appear.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) chk("R10 unexpected response", rsp_rdata, 'x);
      else chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cmp = {32'h0000DEAD, 32'd5, 32'hFFFF_FFFF, 32'h0000_0100};
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 count after reset", count, '0);
    step(0, 1, 0, 0, 0, "R1 R8 cfg after reset");
    step(0, 1, 0, 1, 0, "R1 count lo after reset");
    // R2 ticking, gaps hold
    for (int i = 0; i < 7; i++) step(i != 3, 0, 0, 0, 0, "");
    step(0, 1, 0, 1, 0, "R2 count lo after ticks");
    step(1, 1, 0, 8, 0, "R7 user lo");
    // R5 load ignored while running
    step(0, 1, 1, 1, 32'h1234_5678, "");
    step(0, 1, 0, 1, 0, "R5 load ignored running");
    // R7 user window writes ignored
    step(0, 1, 1, 8, 32'hAAAA_AAAA, "");
    step(0, 1, 1, 9, 32'h5555_5555, "");
    step(0, 1, 0, 8, 0, "R7 user write ignored");
    // R6 high words zero
    step(1, 1, 0, 2, 0, "R6 hi");
    step(1, 1, 0, 9, 0, "R6 user hi");
    // R4 writing current value (0) while running is inert
    step(1, 1, 1, 0, 32'h0, "");
    step(1, 1, 0, 0, 0, "R4 same bit running");
    // R3 halt; ticks ignored
    step(1, 1, 1, 0, 32'h8000_0000, "");
    step(1, 1, 0, 0, 0, "R3 R8 cfg halted");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, "");
    step(1, 1, 0, 1, 0, "R3 hold while halted");
    step(1, 1, 1, 0, 32'h8000_0000, "");
    step(1, 1, 0, 1, 0, "R4 same bit halted");
    // R5 load while halted, R9 match at 0x100
    step(0, 1, 1, 1, 32'h0000_00FE, "");
    step(0, 1, 0, 1, 0, "R5 load halted");
    step(0, 1, 1, 0, 32'h0, "");
    step(0, 1, 0, 0, 0, "R4 restart cfg");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, "");
    step(0, 1, 0, 1, 0, "R4 running after restart");
    // R2 wrap, R9 all-ones compare
    step(0, 1, 1, 0, 32'h8000_0000, "");
    step(0, 1, 1, 1, 32'hFFFF_FFFD, "");
    step(0, 1, 1, 0, 32'h0, "");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, "");
    step(0, 1, 0, 1, 0, "R2 wrap");
    step(0, 1, 0, 5, 0, "R8 unmapped reads zero");
    step(0, 0, 0, 0, 0, "");
    step(0, 0, 0, 0, 0, "");
    chk("R10 all responses seen", CNT_W'(exp_q.size()), '0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule